// File: doc/BRIEF.md
# Configuration Register Access Controller

This block sits behind a serial configuration link and turns single-cycle register requests into accesses to a small configuration RAM, a bank-select register, a read-only identity area, or a refusal. Its access rules depend on whether a valid configuration has been loaded. A `cfg_valid` input carries that state. While no configuration is present, only the configuration RAM and the identity bytes answer, and protection is not enforced. Once a configuration is present, every address answers, and a protection level held in the configuration limits which addresses accept writes.

The configuration is written one byte at a time. The master byte at address 0x00 is written last, and that write raises a one-cycle soft-reset request so that the surrounding logic restarts on the new settings. The link timeout is long by default. A magic value written into the identity area shortens it, which speeds up configuration when no non-volatile memory is fitted. Both timeout limits are given as cycle counts derived from a clock-frequency parameter.

Every response appears one clock after the request. A request that is refused on a read raises `rsp_no_ack` instead of returning data. A refused write is dropped silently.

Top module: `cfg_reg_access`

## Requirements
- R1: After reset, `rsp_ack`, `rsp_no_ack` and `soft_rst_req` are low, `rsp_rdata` is 0x00, `bank_sel` is 0x00 and the long timeout is selected (`timeout_short` low).
- R2: Addresses 0x00 to 0x0C are read/write configuration bytes. An accepted request answers with `rsp_ack` one cycle later, and a read returns the byte last written there. These addresses always reach the configuration bytes, whatever the value of `bank_sel`.
- R3: An accepted write to address 0x00 makes `soft_rst_req` high for exactly the one response cycle of that write, together with `rsp_ack`. No other request raises it.
- R4: While `cfg_valid` is low, a read to 0x0D..0x77 gives `rsp_no_ack` high, `rsp_ack` low and `rsp_rdata` 0x00. A write there is dropped: no ack, and no state change (a write to 0x40 leaves `bank_sel` unchanged). `rsp_no_ack` is never raised while `cfg_valid` is high, and it is never high together with `rsp_ack`.
- R5: Addresses 0x78 to 0x7F read back, in either configuration state, the identity byte `ID_BYTES[8k+7:8k]` for address 0x78+k, together with `rsp_ack`. A write to any of these addresses other than 0x7C gets no ack.
- R6: An accepted write of 0x07 to address 0x7C selects the short timeout, and an accepted write of any other value there selects the long one. Both writes are acked. `timeout_cycles` equals CLK_KHZ*3/1000 when the short timeout is selected and CLK_KHZ*30/1000 when the long one is (150 and 1500 at the default 50 MHz).
- R7: While `cfg_valid` is high, the protection level is bits [1:0] of configuration byte 0x0C. Level 1 or more blocks writes to 0x01..0x0C. Level 2 or more also blocks writes to 0x00 and 0x40. Level 3 also blocks writes to 0x7C. A blocked write gets no ack, changes nothing and raises no soft reset. Reads are never blocked.
- R8: While `cfg_valid` is low, the protection level is ignored and every write to 0x00..0x0C and 0x7C is accepted.
- R9: While `cfg_valid` is high, address 0x40 is a read/write bank-select byte that drives `bank_sel`. Reads to other addresses with no storage return 0x00 with `rsp_ack`, and writes to them are dropped without an ack.
- R10: When `req_wr` and `req_rd` are high in the same cycle, the request is handled as a write only, and `rsp_rdata` stays 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_valid | input | 1 | High while a valid configuration is loaded |
| req_wr | input | 1 | Single-cycle write strobe |
| req_rd | input | 1 | Single-cycle read strobe |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_ack | output | 1 | Request accepted (one cycle after the request) |
| rsp_no_ack | output | 1 | Read refused: no device responds |
| rsp_rdata | output | 8 | Read data, 0x00 when no read is answered |
| soft_rst_req | output | 1 | One-cycle internal reset request |
| timeout_short | output | 1 | High when the short link timeout is selected |
| timeout_cycles | output | TMO_W | Active link timeout in clock cycles |
| bank_sel | output | 8 | Bank-selection byte |

## Verification
The assertions check on every cycle that the two response flags are never both high, and that a refusal only follows a read made while unconfigured. They also check that an unconfigured read of the silent range is always refused, and that identity reads are always answered. Further assertions check that the soft-reset pulse and any change of the timeout selection trace back to a write at the matching address, and that a protected configuration write is never acknowledged. Which data comes back, that a dropped write leaves nothing behind, and how the protection levels, the bank-0 mapping and combined strobes interact can only be shown by the bench. It compares every response against a reference model of the register contents, across directed sequences and seeded random traffic in both configuration states.

// File: rtl/cfgacc_pkg.sv
package cfgacc_pkg;

  typedef enum logic [1:0] {
    RG_CFG  = 2'd0,
    RG_BANK = 2'd1,
    RG_ID   = 2'd2,
    RG_MISC = 2'd3
  } region_e;

  typedef struct packed {
    region_e    region;
    logic       answers;
    logic       writable;
    logic [1:0] prot_rank;
  } dec_t;

  localparam logic [7:0] ADDR_MASTER = 8'h00;
  localparam logic [7:0] ADDR_BANK   = 8'h40;
  localparam logic [4:0] ID_PAGE     = 5'h0F;
  localparam logic [7:0] ADDR_TMO    = 8'h7C;
  localparam logic [7:0] TMO_MAGIC   = 8'h07;

endpackage

// File: rtl/cfgacc_decode.sv
module cfgacc_decode
  import cfgacc_pkg::*;
#(
  parameter int CFG_WORDS = 13
) (
  input  logic [7:0] addr,
  input  logic       cfg_valid,
  output dec_t       dec
);

  localparam logic [7:0] CFG_LAST = 8'(CFG_WORDS - 1);

  always_comb begin
    dec.region    = RG_MISC;
    dec.writable  = 1'b0;
    dec.prot_rank = 2'd0;
    if (addr <= CFG_LAST) begin
      dec.region    = RG_CFG;
      dec.writable  = 1'b1;
      dec.prot_rank = (addr == ADDR_MASTER) ? 2'd2 : 2'd1;
    end else if (addr == ADDR_BANK) begin
      dec.region    = RG_BANK;
      dec.writable  = 1'b1;
      dec.prot_rank = 2'd2;
    end else if (addr[7:3] == ID_PAGE) begin
      dec.region    = RG_ID;
      dec.writable  = (addr == ADDR_TMO);
      dec.prot_rank = (addr == ADDR_TMO) ? 2'd3 : 2'd0;
    end
    dec.answers = cfg_valid || (dec.region == RG_CFG) || (dec.region == RG_ID);
  end

endmodule

// File: rtl/cfgacc_cfg_ram.sv
module cfgacc_cfg_ram #(
  parameter int CFG_WORDS = 13,
  parameter int PROT_ADDR = 12,
  localparam int IW = $clog2(CFG_WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic [1:0]    prot_level
);

  logic [7:0] words [CFG_WORDS];

  for (genvar i = 0; i < CFG_WORDS; i++) begin : g_word
    logic [7:0] word_q;
    logic       word_en;
    assign word_en = we && (idx == IW'(i));
    always_ff @(posedge clk) begin
      if (word_en) begin
        word_q <= wdata;
      end
    end
    assign words[i] = word_q;
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < CFG_WORDS; i++) begin
      if (idx == IW'(i)) begin
        rdata = words[i];
      end
    end
  end

  assign prot_level = words[PROT_ADDR][1:0];

endmodule

// File: rtl/cfgacc_id_rom.sv
module cfgacc_id_rom #(
  parameter logic [63:0] ID_BYTES = 64'h0
) (
  input  logic [2:0] idx,
  output logic [7:0] rdata
);

  logic [7:0] lanes [8];

  for (genvar g = 0; g < 8; g++) begin : g_lane
    assign lanes[g] = ID_BYTES[8*g +: 8];
  end

  assign rdata = lanes[idx];

endmodule

// File: rtl/cfg_reg_access.sv
module cfg_reg_access
  import cfgacc_pkg::*;
#(
  parameter int          CFG_WORDS = 13,
  parameter int          PROT_ADDR = 12,
  parameter int          CLK_KHZ   = 50000,
  parameter int          TMO_W     = 16,
  parameter logic [63:0] ID_BYTES  = 64'h4E_43_69_00_02_01_5A_A5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic             req_wr,
  input  logic             req_rd,
  input  logic [7:0]       req_addr,
  input  logic [7:0]       req_wdata,
  output logic             rsp_ack,
  output logic             rsp_no_ack,
  output logic [7:0]       rsp_rdata,
  output logic             soft_rst_req,
  output logic             timeout_short,
  output logic [TMO_W-1:0] timeout_cycles,
  output logic [7:0]       bank_sel
);

  localparam int IW = $clog2(CFG_WORDS);
  localparam logic [TMO_W-1:0] TMO_LONG_CYC  = TMO_W'(CLK_KHZ * 30 / 1000);
  localparam logic [TMO_W-1:0] TMO_SHORT_CYC = TMO_W'(CLK_KHZ * 3 / 1000);

  dec_t       dec;
  logic [7:0] ram_rdata;
  logic [7:0] rom_rdata;
  logic [1:0] prot_level;
  logic       rd_only;
  logic       blocked;
  logic       wr_ok;
  logic       ram_we;
  logic       bank_we;
  logic       tmo_we;
  logic [7:0] rd_mux;

  logic       ack_d, noack_d, rst_d, short_d;
  logic [7:0] rdata_d, bank_d;
  logic       ack_q, noack_q, rst_q, short_q;
  logic [7:0] rdata_q, bank_q;

  cfgacc_decode #(.CFG_WORDS(CFG_WORDS)) u_decode (
    .addr      (req_addr),
    .cfg_valid (cfg_valid),
    .dec       (dec)
  );

  cfgacc_cfg_ram #(.CFG_WORDS(CFG_WORDS), .PROT_ADDR(PROT_ADDR)) u_ram (
    .clk        (clk),
    .we         (ram_we),
    .idx        (req_addr[IW-1:0]),
    .wdata      (req_wdata),
    .rdata      (ram_rdata),
    .prot_level (prot_level)
  );

  cfgacc_id_rom #(.ID_BYTES(ID_BYTES)) u_rom (
    .idx   (req_addr[2:0]),
    .rdata (rom_rdata)
  );

  // access gating
  always_comb begin
    rd_only = req_rd && !req_wr;
    blocked = cfg_valid && (prot_level != 2'd0) && (dec.prot_rank != 2'd0)
              && (prot_level >= dec.prot_rank);
    wr_ok   = req_wr && dec.answers && dec.writable && !blocked;
    ram_we  = wr_ok && (dec.region == RG_CFG);
    bank_we = wr_ok && (dec.region == RG_BANK);
    tmo_we  = wr_ok && (dec.region == RG_ID);
  end

  always_comb begin
    unique case (dec.region)
      RG_CFG:  rd_mux = ram_rdata;
      RG_BANK: rd_mux = bank_q;
      RG_ID:   rd_mux = rom_rdata;
      default: rd_mux = 8'h00;
    endcase
  end

  // next state
  always_comb begin
    ack_d   = wr_ok || (rd_only && dec.answers);
    noack_d = rd_only && !dec.answers;
    rdata_d = (rd_only && dec.answers) ? rd_mux : 8'h00;
    rst_d   = ram_we && (req_addr == ADDR_MASTER);
    short_d = short_q;
    if (tmo_we) begin
      short_d = (req_wdata == TMO_MAGIC);
    end
    bank_d = bank_q;
    if (bank_we) begin
      bank_d = req_wdata;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      noack_q <= 1'b0;
      rdata_q <= 8'h00;
      rst_q   <= 1'b0;
      short_q <= 1'b0;
      bank_q  <= 8'h00;
    end else begin
      ack_q   <= ack_d;
      noack_q <= noack_d;
      rdata_q <= rdata_d;
      rst_q   <= rst_d;
      if (tmo_we) begin
        short_q <= short_d;
      end
      if (bank_we) begin
        bank_q <= bank_d;
      end
    end
  end

  assign rsp_ack        = ack_q;
  assign rsp_no_ack     = noack_q;
  assign rsp_rdata      = rdata_q;
  assign soft_rst_req   = rst_q;
  assign timeout_short  = short_q;
  assign timeout_cycles = short_q ? TMO_SHORT_CYC : TMO_LONG_CYC;
  assign bank_sel       = bank_q;

endmodule

// File: rtl/cfgacc_checker.sv
module cfgacc_checker #(
  parameter int          CFG_WORDS = 13,
  parameter int          TMO_W     = 16,
  parameter logic [TMO_W-1:0] LONG_CYC  = '0,
  parameter logic [TMO_W-1:0] SHORT_CYC = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_valid,
  input logic             req_wr,
  input logic             req_rd,
  input logic [7:0]       req_addr,
  input logic             rsp_ack,
  input logic             rsp_no_ack,
  input logic             soft_rst_req,
  input logic             timeout_short,
  input logic [TMO_W-1:0] timeout_cycles,
  input logic [1:0]       prot_level
);

  localparam logic [7:0] CFG_LAST = 8'(CFG_WORDS - 1);

  AST_RSP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_ack && rsp_no_ack)); // R4

  AST_NOACK_UNCFG: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_no_ack |-> ($past(!cfg_valid) && $past(req_rd) && !$past(req_wr))); // R4

  AST_UNCFG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !req_wr && !cfg_valid && req_addr > CFG_LAST && req_addr < 8'h78)
    |=> rsp_no_ack); // R4

  AST_ID_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !req_wr && req_addr >= 8'h78) |=> rsp_ack); // R5

  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |-> ($past(req_wr) && $past(req_addr) == 8'h00 && rsp_ack)); // R3

  AST_RST_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && req_addr == 8'h00 && (!cfg_valid || prot_level < 2'd2))
    |=> soft_rst_req); // R3

  AST_TMO_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_cycles == LONG_CYC) || (timeout_cycles == SHORT_CYC)); // R6

  AST_TMO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(timeout_short) |-> ($past(req_wr) && $past(req_addr) == 8'h7C)); // R6

  AST_PROT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && cfg_valid && prot_level != 2'd0 && req_addr != 8'h00 && req_addr <= CFG_LAST)
    |=> !rsp_ack); // R7

  AST_CFG_READ_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !req_wr && cfg_valid) |=> rsp_ack); // R9

endmodule

bind cfg_reg_access cfgacc_checker #(
  .CFG_WORDS (CFG_WORDS),
  .TMO_W     (TMO_W),
  .LONG_CYC  (TMO_LONG_CYC),
  .SHORT_CYC (TMO_SHORT_CYC)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_valid      (cfg_valid),
  .req_wr         (req_wr),
  .req_rd         (req_rd),
  .req_addr       (req_addr),
  .rsp_ack        (rsp_ack),
  .rsp_no_ack     (rsp_no_ack),
  .soft_rst_req   (soft_rst_req),
  .timeout_short  (timeout_short),
  .timeout_cycles (timeout_cycles),
  .prot_level     (prot_level)
);

// File: tb/cfg_reg_access_tb_top.sv
module cfg_reg_access_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam logic [63:0] ID_VAL     = 64'h4E_43_69_00_02_01_5A_A5;
  localparam int          T_LONG     = 1500;
  localparam int          T_SHORT    = 150;

  logic        clk;
  logic        rst_n;
  logic        cfg_valid;
  logic        req_wr;
  logic        req_rd;
  logic [7:0]  req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_ack;
  logic        rsp_no_ack;
  logic [7:0]  rsp_rdata;
  logic        soft_rst_req;
  logic        timeout_short;
  logic [15:0] timeout_cycles;
  logic [7:0]  bank_sel;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [7:0] m_ram [13];
  logic [7:0] m_bank;
  logic       m_short;

  cfg_reg_access #(.ID_BYTES(ID_VAL)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_valid      (cfg_valid),
    .req_wr         (req_wr),
    .req_rd         (req_rd),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .rsp_ack        (rsp_ack),
    .rsp_no_ack     (rsp_no_ack),
    .rsp_rdata      (rsp_rdata),
    .soft_rst_req   (soft_rst_req),
    .timeout_short  (timeout_short),
    .timeout_cycles (timeout_cycles),
    .bank_sel       (bank_sel)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // requirement-driven reference for one request
  task automatic xfer(input logic wr, input logic rd, input logic [7:0] a,
                      input logic [7:0] d, input logic cv);
    bit is_cfg, is_bank, is_id, answers, writable, blocked, wok, rd_only;
    int rank, lvl;
    logic [7:0] val;
    string tag;
    is_cfg   = (a <= 8'h0C);
    is_bank  = (a == 8'h40);
    is_id    = (a >= 8'h78);
    answers  = cv || is_cfg || is_id;
    writable = is_cfg || is_bank || (a == 8'h7C);
    rank     = is_cfg ? ((a == 8'h00) ? 2 : 1) : (is_bank ? 2 : ((a == 8'h7C) ? 3 : 0));
    lvl      = int'(m_ram[12][1:0]);
    blocked  = cv && lvl != 0 && rank != 0 && lvl >= rank;
    wok      = wr && answers && writable && !blocked;
    rd_only  = rd && !wr;
    val      = is_cfg ? m_ram[a[3:0]] : (is_bank ? m_bank : (is_id ? ID_VAL[8*a[2:0] +: 8] : 8'h00));
    if (wr && rd)                    tag = "R10";
    else if (!cv && !answers)        tag = "R4";
    else if (blocked)                tag = "R7";
    else if (a == 8'h7C && wr)       tag = "R6";
    else if (is_id)                  tag = "R5";
    else if (is_cfg && wr && a == 0) tag = "R3";
    else if (is_cfg && !cv && wr)    tag = "R8";
    else if (is_cfg)                 tag = "R2";
    else                             tag = "R9";
    cfg_valid = cv;
    req_wr    = wr;
    req_rd    = rd;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_wr = 1'b0;
    req_rd = 1'b0;
    if (wok) begin
      if (is_cfg)  m_ram[a[3:0]] = d;
      if (is_bank) m_bank = d;
      if (a == 8'h7C) m_short = (d == 8'h07);
    end
    chk(tag, "ack",     int'(rsp_ack),      int'(wok || (rd_only && answers)));
    chk(tag, "no_ack",  int'(rsp_no_ack),   int'(rd_only && !answers));
    chk(tag, "rdata",   int'(rsp_rdata),    (rd_only && answers) ? int'(val) : 0);
    chk(tag, "softrst", int'(soft_rst_req), int'(wok && a == 8'h00));
    chk(tag, "tmo",     int'(timeout_cycles), m_short ? T_SHORT : T_LONG);
    chk(tag, "bank",    int'(bank_sel),     int'(m_bank));
  endtask

  function automatic logic [7:0] pick_addr(input int r);
    case (r % 6)
      0, 1: pick_addr = 8'(r % 13);
      2:    pick_addr = 8'h78 + 8'(r % 8);
      3:    pick_addr = 8'h40;
      4:    pick_addr = 8'h7C;
      default: pick_addr = 8'(r % 128);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_valid = 1'b0; req_wr = 1'b0; req_rd = 1'b0;
    req_addr = 8'h00; req_wdata = 8'h00;
    m_bank = 8'h00; m_short = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "ack",     int'(rsp_ack), 0);
    chk("R1", "no_ack",  int'(rsp_no_ack), 0);
    chk("R1", "softrst", int'(soft_rst_req), 0);
    chk("R1", "rdata",   int'(rsp_rdata), 0);
    chk("R1", "short",   int'(timeout_short), 0);
    chk("R1", "tmo",     int'(timeout_cycles), T_LONG);
    chk("R1", "bank",    int'(bank_sel), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: unconfigured load, level 3 written but ignored; master byte last (R3)
    for (int i = 12; i >= 0; i--) begin
      xfer(1'b1, 1'b0, 8'(i), (i == 12) ? 8'h03 : 8'(8'h30 + i), 1'b0);
    end
    for (int i = 0; i < 13; i++) xfer(1'b0, 1'b1, 8'(i), 8'h00, 1'b0); // R2
    xfer(1'b1, 1'b0, 8'h05, 8'h99, 1'b0);   // R8 write under level 3
    xfer(1'b0, 1'b1, 8'h05, 8'h00, 1'b0);

    // R4: silent area while unconfigured
    xfer(1'b0, 1'b1, 8'h0D, 8'h00, 1'b0);
    xfer(1'b0, 1'b1, 8'h40, 8'h00, 1'b0);
    xfer(1'b0, 1'b1, 8'h77, 8'h00, 1'b0);
    xfer(1'b1, 1'b0, 8'h40, 8'h05, 1'b0);   // dropped, bank stays 0

    // R5: identity bytes in both states
    for (int i = 0; i < 8; i++) xfer(1'b0, 1'b1, 8'h78 + 8'(i), 8'h00, 1'b0);
    xfer(1'b1, 1'b0, 8'h79, 8'h11, 1'b0);
    xfer(1'b0, 1'b1, 8'h7F, 8'h00, 1'b1);

    // R6: timeout selection
    xfer(1'b1, 1'b0, 8'h7C, 8'h07, 1'b0);
    xfer(1'b1, 1'b0, 8'h7C, 8'h01, 1'b0);
    xfer(1'b1, 1'b0, 8'h7C, 8'h07, 1'b0);

    // R7: level 3 while configured
    xfer(1'b1, 1'b0, 8'h05, 8'h44, 1'b1);
    xfer(1'b0, 1'b1, 8'h05, 8'h00, 1'b1);
    xfer(1'b1, 1'b0, 8'h00, 8'h44, 1'b1);
    xfer(1'b1, 1'b0, 8'h7C, 8'h00, 1'b1);
    xfer(1'b1, 1'b0, 8'h40, 8'h02, 1'b1);

    // level 1: bank writable, master writable, config bytes locked
    xfer(1'b1, 1'b0, 8'h0C, 8'h01, 1'b0);
    xfer(1'b1, 1'b0, 8'h40, 8'h03, 1'b1);   // R9
    xfer(1'b0, 1'b1, 8'h40, 8'h00, 1'b1);   // R9
    xfer(1'b0, 1'b1, 8'h03, 8'h00, 1'b1);   // R2 bank 0 mapping
    xfer(1'b1, 1'b0, 8'h06, 8'h66, 1'b1);   // R7 blocked
    xfer(1'b1, 1'b0, 8'h00, 8'h5A, 1'b1);   // R3 allowed
    xfer(1'b1, 1'b1, 8'h02, 8'h22, 1'b0);   // R10
    xfer(1'b0, 1'b1, 8'h02, 8'h00, 1'b0);
    xfer(1'b0, 1'b1, 8'h20, 8'h00, 1'b1);   // R9 reads 0
    xfer(1'b1, 1'b0, 8'h20, 8'h77, 1'b1);   // R9 dropped

    // seeded random traffic
    for (int n = 0; n < 800; n++) begin
      int r, k;
      logic [7:0] a, d;
      r = int'($urandom() & 32'h7FFF_FFFF);
      a = pick_addr(r);
      k = (r >> 8) % 4;
      d = ((r >> 12) % 3 == 0) ? 8'h07 : 8'($urandom());
      if (a == 8'h0C) d = {6'd0, d[1:0]};
      xfer(k == 0 || k == 3, k >= 1, a, d, ((r >> 16) % 2) == 1);
    end

    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule